// File: doc/BRIEF.md
# Serial Waveform Memory Loader

This block fills and reads back a 1024-word by 32-bit waveform memory through a serial port that clocks one bit per serial clock. The serial stream carries only data; it never carries an address. The memory address comes instead from one of eight profiles, picked by a 3-bit profile select input. Each profile gives a first and a last address. When chip select goes active, an internal counter loads the selected first address. The counter then moves up by one each time a 32-bit word has been assembled from the serial bits, or each time a word has been fully shifted out.

A transfer is a write or a read, chosen by the `rw_rd` input. A write assembles each group of 32 bits, most significant bit first, into one word and stores it at the counter's address. A read fetches the word at the counter's address before its first bit is needed. It then drives that word out of `sdo`, most significant bit first. Once the last address of the profile has been handled, the counter stops and the rest of the transfer has no effect.

The transfer is blocked if the waveform enable (`ram_en`) is high when it starts, or if the profile's last address is not greater than its first. A blocked transfer writes nothing, drives zeros on a read, and raises `busy_err` or `range_err`. An I/O reset input abandons the current word and restarts the counter at the first address. It leaves the memory contents as they are.

Top module: `wave_ram_loader`

## Requirements
- R1: After `rst_n` is asserted, `sdo`, `busy_err` and `range_err` are 0.
- R2: In a write transfer, the first 32 bits after chip select goes low (`csn`=0, `rw_rd`=0) form one word, most significant bit first. That word is stored at the profile's first address, and each following word goes to the next higher address.
- R3: In a read transfer (`rw_rd`=1), `sdo` carries bit 31 of the word at the first address before the first serial clock edge. Each edge then moves to the next lower bit, and after bit 0 comes bit 31 of the word at the next address.
- R4: After the word at the profile's last address, further words of the same transfer write nothing, and on a read `sdo` stays 0.
- R5: Profile ranges may overlap. A later write to a shared address replaces the word written there earlier.
- R6: If `ram_en` is 1 while chip select is inactive before a transfer, `busy_err` is 1 for that transfer, nothing is written, and a read drives `sdo` = 0.
- R7: If the selected profile's last address is less than or equal to its first address, `range_err` is 1, nothing is written, and a read drives `sdo` = 0.
- R8: A one-cycle pulse on `io_rst` during a transfer drops the partial word and clears the bit count. The next complete word goes to the profile's first address, and earlier memory contents are kept.
- R9: If chip select goes inactive in the middle of a word, that partial word is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; `sdi` is sampled and `sdo` updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Active-low chip select |
| io_rst | input | 1 | Synchronous I/O reset: restart the current transfer |
| rw_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdo | output | 1 | Serial data out, most significant bit first |
| prof_sel | input | 3 | Profile select |
| prof_first | input | 80 | First addresses; profile k uses bits [10k+9:10k] |
| prof_last | input | 80 | Last addresses; profile k uses bits [10k+9:10k] |
| ram_en | input | 1 | Waveform enable; must be 0 for a transfer to take effect |
| busy_err | output | 1 | Transfer started while `ram_en` was 1 |
| range_err | output | 1 | Selected profile's last address is not above its first |

## Verification
The bench writes more words than a range holds and reads past the last address. A counter that failed to stop would overwrite the neighbouring location or shift out stale data. Overlapping ranges are written one after the other and read back, which catches a write that is dropped or that lands one address off. An `io_rst` pulse in the middle of a word is followed by full words; a design that kept the bit count would misalign every later word. A chip select that goes inactive mid-word, a busy start and a range where first equals last are each followed by a readback of the addresses they could have corrupted. Any write leaking through would change those words.

// File: rtl/wrl_pkg.sv
package wrl_pkg;
  localparam int WORD_W = 32;
  localparam int DEPTH = 1024;
  localparam int NPROF = 8;

  // A range is usable only when its last address is strictly above its first.
  function automatic logic range_ok(input int first_a, input int last_a);
    return last_a > first_a;
  endfunction

  // True on the serial clock that carries the final bit of a word.
  function automatic logic last_bit(input int cnt, input int width);
    return cnt == width - 1;
  endfunction
endpackage

// File: rtl/wrl_mem.sv
module wrl_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/wrl_shift.sv
module wrl_shift #(
  parameter int WIDTH = 32,
  localparam int BCW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic             sdi,
  input  logic [WIDTH-1:0] load_word,
  output logic [BCW-1:0]   bit_cnt,
  output logic             word_end,
  output logic [WIDTH-1:0] rx_word,
  output logic             tx_msb
);
  import wrl_pkg::*;

  logic [WIDTH-1:0] rx_sh;
  logic [WIDTH-1:0] tx_sh;

  assign word_end = active && last_bit(int'(bit_cnt), WIDTH);
  assign rx_word  = {rx_sh[WIDTH-2:0], sdi};
  assign tx_msb   = tx_sh[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (restart) begin
      bit_cnt <= '0;
      tx_sh   <= load_word;
    end else if (active) begin
      rx_sh <= rx_word;
      if (word_end) begin
        bit_cnt <= '0;
        tx_sh   <= load_word;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        tx_sh   <= {tx_sh[WIDTH-2:0], 1'b0};
      end
    end
  end

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> bit_cnt == '0);
  // R2
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> bit_cnt == '0);
endmodule

// File: rtl/wrl_addr_ctr.sv
module wrl_addr_ctr #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [AW-1:0] first_in,
  input  logic [AW-1:0] last_in,
  output logic [AW-1:0] addr,
  output logic          done,
  output logic          has_next
);
  logic [AW-1:0] last_q;

  assign has_next = !done && (addr != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      last_q <= '0;
      done   <= 1'b0;
    end else if (restart) begin
      addr   <= first_in;
      last_q <= last_in;
      done   <= 1'b0;
    end else if (step && !done) begin
      if (addr == last_q) done <= 1'b1;
      else addr <= addr + 1'b1;
    end
  end

  // R8
  restart_loads_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> addr == $past(first_in));
  // R2
  step_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && has_next && !restart) |=> addr == $past(addr) + 1'b1);
  // R4
  stop_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> $stable(addr) && done);
endmodule

// File: rtl/wave_ram_loader.sv
module wave_ram_loader #(
  parameter int WIDTH = wrl_pkg::WORD_W,
  parameter int DEPTH = wrl_pkg::DEPTH,
  parameter int NPROF = wrl_pkg::NPROF,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(NPROF),
  localparam int BCW = $clog2(WIDTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csn,
  input  logic            io_rst,
  input  logic            rw_rd,
  input  logic            sdi,
  output logic            sdo,
  input  logic [PW-1:0]   prof_sel,
  input  logic [NPROF*AW-1:0] prof_first,
  input  logic [NPROF*AW-1:0] prof_last,
  input  logic            ram_en,
  output logic            busy_err,
  output logic            range_err
);
  import wrl_pkg::*;

  logic [AW-1:0]    first_tab [NPROF];
  logic [AW-1:0]    last_tab  [NPROF];
  logic [AW-1:0]    first_sel, last_sel;
  logic             restart, active, blocked;
  logic [BCW-1:0]   bit_cnt;
  logic             word_end, tx_msb;
  logic [WIDTH-1:0] rx_word, rd_word, load_word;
  logic [AW-1:0]    addr, rd_addr;
  logic             done, has_next, wr_stb, rd_stb;

  for (genvar k = 0; k < NPROF; k++) begin : g_prof
    assign first_tab[k] = prof_first[k*AW +: AW];
    assign last_tab[k]  = prof_last[k*AW +: AW];
  end

  assign first_sel = first_tab[prof_sel];
  assign last_sel  = last_tab[prof_sel];
  assign restart   = csn || io_rst;
  assign active    = !csn && !io_rst;
  assign blocked   = busy_err || range_err;

  // Flags follow the conditions while idle and freeze once the transfer runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_err  <= 1'b0;
      range_err <= 1'b0;
    end else if (csn) begin
      busy_err  <= ram_en;
      range_err <= !range_ok(int'(first_sel), int'(last_sel));
    end
  end

  wrl_shift #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .restart(restart), .active(active), .sdi(sdi),
    .load_word(load_word), .bit_cnt(bit_cnt), .word_end(word_end),
    .rx_word(rx_word), .tx_msb(tx_msb)
  );

  wrl_addr_ctr #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(word_end),
    .first_in(first_sel), .last_in(last_sel), .addr(addr), .done(done),
    .has_next(has_next)
  );

  // Prefetch: first word while idle, next word as the current one completes.
  assign rd_addr   = restart ? first_sel : addr + 1'b1;
  assign rd_stb    = restart || (word_end && has_next);
  assign load_word = rd_stb ? rd_word : '0;
  assign wr_stb    = word_end && !rw_rd && !done && !blocked;

  wrl_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_stb), .waddr(addr), .wdata(rx_word),
    .raddr(rd_addr), .rdata(rd_word)
  );

  assign sdo = rw_rd && !csn && !blocked && tx_msb;

  // R6
  no_wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> !wr_stb);
  // R7
  no_wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> !wr_stb);
  // R4
  no_wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_stb);
  // R9
  wr_on_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !csn && bit_cnt == BCW'(WIDTH - 1));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !sdo);
endmodule

// File: tb/tb_wave_ram_loader.sv
module tb_wave_ram_loader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0, csn = 1'b1, io_rst = 1'b0, rw_rd = 1'b0;
  logic sdi = 1'b0, ram_en = 1'b0;
  logic [2:0] prof_sel = '0;
  logic [8*AW-1:0] prof_first, prof_last;
  logic sdo, busy_err, range_err;

  int pfirst [8] = '{0, 4, 2, 5, 20, 9, 1020, 30};
  int plast  [8] = '{3, 5, 6, 5, 21, 8, 1023, 31};
  logic [31:0] ref_mem [1024];
  logic [31:0] wbuf [8];
  int checks = 0, errors = 0;

  // {profile, word0, word1}
  localparam logic [66:0] VEC [6] = '{
    {3'd0, 32'h1234_5678, 32'h9ABC_DEF0},
    {3'd1, 32'hFFFF_0000, 32'h0000_FFFF},
    {3'd4, 32'h8000_0001, 32'h7FFF_FFFE},
    {3'd6, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    {3'd7, 32'hA5A5_5A5A, 32'h0F0F_F0F0},
    {3'd0, 32'h0000_0001, 32'h8000_0000}
  };

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      prof_first[k*AW +: AW] = AW'(pfirst[k]);
      prof_last[k*AW +: AW]  = AW'(plast[k]);
    end
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_ram_loader dut (
    .clk(clk), .rst_n(rst_n), .csn(csn), .io_rst(io_rst), .rw_rd(rw_rd),
    .sdi(sdi), .sdo(sdo), .prof_sel(prof_sel), .prof_first(prof_first),
    .prof_last(prof_last), .ram_en(ram_en), .busy_err(busy_err),
    .range_err(range_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_select(input int p);
    csn = 1'b1; prof_sel = 3'(p);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      sdi = w[31-k];
      @(negedge clk);
    end
  endtask

  // Writes n words from wbuf and updates the reference where the rules allow.
  task automatic wr(input int p, input int n);
    idle_select(p);
    csn = 1'b0; rw_rd = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_bits(wbuf[i], 32);
      if (!ram_en && plast[p] > pfirst[p] && pfirst[p] + i <= plast[p])
        ref_mem[pfirst[p] + i] = wbuf[i];
    end
    csn = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input int p, input int n, input string req);
    logic [31:0] got, exp;
    idle_select(p);
    csn = 1'b0; rw_rd = 1'b1;
    for (int i = 0; i < n; i++) begin
      got = '0;
      for (int k = 0; k < 32; k++) begin
        #1 got[31-k] = sdo;
        @(negedge clk);
      end
      exp = (ram_en || plast[p] <= pfirst[p] || pfirst[p] + i > plast[p])
            ? 32'h0 : ref_mem[pfirst[p] + i];
      check(req, got, exp);
    end
    csn = 1'b1; rw_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
    #1;
    // R1: reset state
    check("R1 sdo", {31'b0, sdo}, 32'h0);
    check("R1 busy_err", {31'b0, busy_err}, 32'h0);
    check("R1 range_err", {31'b0, range_err}, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: table-driven write then readback
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][63:32];
      wbuf[1] = VEC[v][31:0];
      wr(int'(VEC[v][66:64]), 2);
      rd(int'(VEC[v][66:64]), 2, "R2/R3 table readback");
    end

    // R5: overlapping ranges, profile 2 (2..6) overwrites 2,3 of profile 0
    for (int i = 0; i < 4; i++) wbuf[i] = 32'hA000_0000 + i;
    wr(0, 4);
    for (int i = 0; i < 5; i++) wbuf[i] = 32'hB000_0000 + i;
    wr(2, 5);
    rd(0, 4, "R5 overlap");

    // R4: three words into a two-word range; address 6 must survive
    for (int i = 0; i < 3; i++) wbuf[i] = 32'hC000_0000 + i;
    wr(1, 3);
    rd(2, 5, "R4 no write past last");
    rd(1, 3, "R4 zeros past last");

    // R6: busy start
    ram_en = 1'b1;
    idle_select(7);
    check("R6 busy_err", {31'b0, busy_err}, 32'h1);
    wbuf[0] = 32'h1111_2222; wbuf[1] = 32'h3333_4444;
    wr(7, 2);
    rd(7, 1, "R6 read blocked");
    ram_en = 1'b0;
    rd(7, 2, "R6 contents kept");

    // R7: first == last
    idle_select(3);
    check("R7 range_err", {31'b0, range_err}, 32'h1);
    wbuf[0] = 32'h5555_AAAA;
    wr(3, 1);
    rd(3, 1, "R7 read blocked");
    rd(2, 5, "R7 address 5 kept");
    idle_select(5);
    check("R7 range_err reversed", {31'b0, range_err}, 32'h1);
    idle_select(0);
    check("R7 range_err clear", {31'b0, range_err}, 32'h0);

    // R8: io_rst mid-word
    idle_select(4);
    csn = 1'b0; rw_rd = 1'b0;
    send_bits(32'hFFFF_FFFF, 16);
    io_rst = 1'b1; @(negedge clk); io_rst = 1'b0;
    send_bits(32'hD00D_0001, 32);
    send_bits(32'hE00E_0002, 32);
    csn = 1'b1; @(negedge clk);
    ref_mem[20] = 32'hD00D_0001; ref_mem[21] = 32'hE00E_0002;
    rd(4, 2, "R8 io_rst realign");
    rd(0, 4, "R8 other contents kept");

    // R9: partial word abandoned by chip select
    idle_select(7);
    csn = 1'b0;
    send_bits(32'h0000_0000, 10);
    csn = 1'b1; @(negedge clk);
    rd(7, 2, "R9 partial not written");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule